// File: doc/BRIEF.md
# Transmit FIFO Threshold DMA Controller

This block sits between a bus-master read engine and a transmit MAC. It tracks how full the on-chip transmit packet FIFO is and decides when to ask for the bus to refill it. Once the bus is granted, it takes dwords from the host side into the FIFO. It also decides when the MAC may start pulling a packet out. The FIFO holds 2 KB (512 dwords), and up to four complete packets may sit in it at once, so frames can leave back to back.

A fill threshold and a drain threshold are both given in 32-byte units (8 dwords per unit). A request is raised only when the free space reaches the fill threshold. A new packet is offered to the MAC only when the buffered amount reaches the drain threshold, or when a whole packet is already resident. A burst ends at the programmed burst length (capped at 128 dwords), when the FIFO fills, or when the fourth resident packet completes. An 8-bit latency timer is loaded when ownership begins and counts down once per cycle. If grant is withdrawn, ownership is kept until the timer reaches zero.

Top module: `tx_fifo_dma_ctrl`

## Requirements
- R1: `busReq` is high only while `hostPend` is high, `busOwn` is low, the FIFO is not full, and the free dwords are at least `fillThr`*8. It is high whenever all of these hold and fewer than 4 packets are resident.
- R2: While 4 complete packets are resident, `busReq` stays low. A burst ends with the dword carrying `hostLast` that completes the fourth resident packet. Popping a packet's last dword re-enables the request.
- R3: When `busReq` and `busGnt` are both high at a clock edge, `busOwn` is high from that edge. While it stays high, each cycle with `hostValid` high writes one dword (`hostData`, `hostLast`) into the FIFO.
- R4: A burst ends after the effective burst length has been written. That length is `maxBurst`, except that 0 or any value above 128 means 128 dwords.
- R5: A burst ends when its write fills the FIFO at 512 dwords. A full FIFO never takes a write and never raises `busReq`.
- R6: `latCfg` is loaded into the latency timer when ownership begins. The timer counts down once per owned cycle. If `busGnt` is low, ownership lasts through the cycle in which the timer reads zero, so a grant dropped in the first owned cycle gives `latCfg`+1 owned cycles. While `busGnt` stays high, an expired timer does not end ownership.
- R7: With `latCfg` = 0, a grant withdrawal ends ownership at the next edge, after at most one more dword.
- R8: `macValid` offers a new packet only when the FIFO holds at least max(`drainThr`,1)*8 dwords or a complete packet. Once the first dword of a packet is popped, `macValid` stays high while the FIFO is not empty, until that packet's last dword is popped.
- R9: A `drainThr` of 0 acts as one unit (8 dwords).
- R10: `macData` and `macLast` present the written dwords in write order. `macLast` is set exactly on a dword written with `hostLast`. A pop happens on an edge where `macPop` and `macValid` are both high.
- R11: After reset, the FIFO is empty, no packets are resident, and `busOwn`, `macValid` and (with `hostPend` low) `busReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillThr | input | 6 | Free space needed before requesting, in 32-byte units |
| drainThr | input | 6 | Buffered amount needed before a packet starts, in 32-byte units |
| maxBurst | input | 8 | Burst length in dwords (0 or >128 means 128) |
| latCfg | input | 8 | Latency timer load value |
| hostPend | input | 1 | Host has packet data waiting to be fetched |
| busGnt | input | 1 | Bus grant from the arbiter |
| busReq | output | 1 | Bus request |
| busOwn | output | 1 | Bus tenure active (frame driven) |
| hostValid | input | 1 | A dword is on `hostData` in this owned cycle |
| hostData | input | 32 | Dword read from host memory |
| hostLast | input | 1 | This dword ends a packet |
| macPop | input | 1 | MAC takes the head dword |
| macValid | output | 1 | Head dword may be taken by the MAC |
| macData | output | 32 | Head dword |
| macLast | output | 1 | Head dword ends a packet |

## Verification
`busReq` and `macValid` are combinational over registered occupancy. A write or pop therefore changes them one edge after the strobe, and a threshold input change shows in the same cycle. `busOwn` rises on the edge that samples request and grant together, and falls on the edge that ends the burst. A grant dropped in the first owned cycle gives exactly `latCfg`+1 owned cycles. The bench drives every input on the falling edge and samples every output on the falling edge, half a cycle after the registers move. Counts of owned cycles, and the data of each popped dword, are thus read once per cycle with no race.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobe_t;
endpackage

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int DEPTH_DW = 512,
  parameter int DATA_W   = 32,
  parameter int MAX_PKT  = 4,
  parameter int CNT_W    = $clog2(DEPTH_DW + 1),
  parameter int PKT_W    = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic [CNT_W-1:0]  usedDw,
  output logic [PKT_W-1:0]  pktCnt,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH_DW);

  logic [DATA_W:0]  mem [DEPTH_DW];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             pktIn;
  logic             pktOut;

  assign full   = (usedDw == CNT_W'(DEPTH_DW));
  assign empty  = (usedDw == '0);
  assign rdData = mem[rdPtr][DATA_W-1:0];
  assign rdLast = mem[rdPtr][DATA_W];
  assign pktIn  = strobe.wrEn && wrLast;
  assign pktOut = strobe.rdEn && rdLast;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      usedDw <= '0;
      pktCnt <= '0;
    end else begin
      if (strobe.wrEn)
        wrPtr <= (wrPtr == PTR_W'(DEPTH_DW - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (strobe.rdEn)
        rdPtr <= (rdPtr == PTR_W'(DEPTH_DW - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({strobe.wrEn, strobe.rdEn})
        2'b10:   usedDw <= usedDw + CNT_W'(1);
        2'b01:   usedDw <= usedDw - CNT_W'(1);
        default: usedDw <= usedDw;
      endcase
      case ({pktIn, pktOut})
        2'b10:   pktCnt <= pktCnt + PKT_W'(1);
        2'b01:   pktCnt <= pktCnt - PKT_W'(1);
        default: pktCnt <= pktCnt;
      endcase
    end
  end

  // R5: the control must never write into a full FIFO
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> !full);
  // R10: the control must never pop an empty FIFO
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> !empty);
  // R2: resident packet count stays within the limit
  assert_pkt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    pktCnt <= PKT_W'(MAX_PKT));
endmodule

// File: rtl/txdma_control.sv
module txdma_control
  import txdma_pkg::*;
#(
  parameter int DEPTH_DW     = 512,
  parameter int MAX_PKT      = 4,
  parameter int THR_W        = 6,
  parameter int LAT_W        = 8,
  parameter int BURST_W      = 8,
  parameter int MAX_BURST_DW = 128,
  parameter int UNIT_DW      = 8,
  parameter int CNT_W        = $clog2(DEPTH_DW + 1),
  parameter int PKT_W        = $clog2(MAX_PKT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THR_W-1:0]   fillThr,
  input  logic [THR_W-1:0]   drainThr,
  input  logic [BURST_W-1:0] maxBurst,
  input  logic [LAT_W-1:0]   latCfg,
  input  logic               hostPend,
  input  logic               busGnt,
  input  logic               hostValid,
  input  logic               hostLast,
  input  logic               macPop,
  input  logic [CNT_W-1:0]   usedDw,
  input  logic [PKT_W-1:0]   pktCnt,
  input  logic               full,
  input  logic               empty,
  input  logic               headLast,
  output logic               busReq,
  output logic               busOwn,
  output logic               macValid,
  output fifoStrobe_t        strobe
);
  localparam int BCNT_W = $clog2(MAX_BURST_DW + 1);

  logic [BCNT_W-1:0] burstCnt;
  logic [BCNT_W-1:0] effBurst;
  logic [LAT_W-1:0]  latTimer;
  logic [CNT_W-1:0]  freeDw;
  logic [CNT_W-1:0]  fillNeed;
  logic [CNT_W-1:0]  drainNeed;
  logic [THR_W-1:0]  drainUnits;
  logic              sending;
  logic              wrNow;
  logic              rdNow;
  logic              startOwn;
  logic              burstHit;
  logic              fullHit;
  logic              pktHit;
  logic              latHit;
  logic              endBurst;

  // Occupancy thresholds, compared in dwords
  always_comb begin
    freeDw     = CNT_W'(DEPTH_DW) - usedDw;
    fillNeed   = CNT_W'(fillThr) * CNT_W'(UNIT_DW);
    drainUnits = (drainThr == '0) ? THR_W'(1) : drainThr;
    drainNeed  = CNT_W'(drainUnits) * CNT_W'(UNIT_DW);
    if (maxBurst == '0 || int'(maxBurst) > MAX_BURST_DW)
      effBurst = BCNT_W'(MAX_BURST_DW);
    else
      effBurst = BCNT_W'(maxBurst);
  end

  assign busReq   = !busOwn && hostPend && !full
                    && (pktCnt < PKT_W'(MAX_PKT)) && (freeDw >= fillNeed);
  assign startOwn = busReq && busGnt;

  assign macValid = !empty && (sending || (usedDw >= drainNeed) || (pktCnt != '0));

  assign wrNow = busOwn && hostValid && !full;
  assign rdNow = macPop && macValid;
  assign strobe.wrEn = wrNow;
  assign strobe.rdEn = rdNow;

  // Reasons a tenure ends at the coming edge
  always_comb begin
    burstHit = wrNow && ((burstCnt + BCNT_W'(1)) == effBurst);
    fullHit  = wrNow && !rdNow && (usedDw == CNT_W'(DEPTH_DW - 1));
    pktHit   = wrNow && hostLast && (pktCnt == PKT_W'(MAX_PKT - 1))
               && !(rdNow && headLast);
    latHit   = !busGnt && (latTimer == '0);
    endBurst = busOwn && (burstHit || fullHit || pktHit || latHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOwn   <= 1'b0;
      burstCnt <= '0;
      latTimer <= '0;
      sending  <= 1'b0;
    end else begin
      if (busOwn) busOwn <= !endBurst;
      else        busOwn <= startOwn;

      if (startOwn)   burstCnt <= '0;
      else if (wrNow) burstCnt <= burstCnt + BCNT_W'(1);

      if (startOwn)                       latTimer <= latCfg;
      else if (busOwn && latTimer != '0)  latTimer <= latTimer - LAT_W'(1);

      if (rdNow) sending <= !headLast;
    end
  end

  // R3: request plus grant always opens a tenure
  assert_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt) |=> busOwn);
  // R6: timer holds the configured value at the start of a tenure
  assert_timer_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwn) |-> (latTimer == $past(latCfg)));
  // R7: expired timer with no grant ends the tenure at the next edge
  assert_lat_expiry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busOwn && !busGnt && latTimer == '0) |=> !busOwn);
  // R2: no request while the packet limit is reached
  assert_req_pkt_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (pktCnt < PKT_W'(MAX_PKT)));
  // R8: data is only offered from a non-empty FIFO
  assert_valid_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    macValid |-> !empty);
endmodule

// File: rtl/tx_fifo_dma_ctrl.sv
module tx_fifo_dma_ctrl
  import txdma_pkg::*;
#(
  parameter int DEPTH_DW     = 512,
  parameter int DATA_W       = 32,
  parameter int MAX_PKT      = 4,
  parameter int THR_W        = 6,
  parameter int LAT_W        = 8,
  parameter int BURST_W      = 8,
  parameter int MAX_BURST_DW = 128,
  parameter int UNIT_DW      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THR_W-1:0]   fillThr,
  input  logic [THR_W-1:0]   drainThr,
  input  logic [BURST_W-1:0] maxBurst,
  input  logic [LAT_W-1:0]   latCfg,
  input  logic               hostPend,
  input  logic               busGnt,
  output logic               busReq,
  output logic               busOwn,
  input  logic               hostValid,
  input  logic [DATA_W-1:0]  hostData,
  input  logic               hostLast,
  input  logic               macPop,
  output logic               macValid,
  output logic [DATA_W-1:0]  macData,
  output logic               macLast
);
  localparam int CNT_W = $clog2(DEPTH_DW + 1);
  localparam int PKT_W = $clog2(MAX_PKT + 1);

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] usedDw;
  logic [PKT_W-1:0] pktCnt;
  logic             full;
  logic             empty;

  txdma_control #(
    .DEPTH_DW(DEPTH_DW), .MAX_PKT(MAX_PKT), .THR_W(THR_W), .LAT_W(LAT_W),
    .BURST_W(BURST_W), .MAX_BURST_DW(MAX_BURST_DW), .UNIT_DW(UNIT_DW),
    .CNT_W(CNT_W), .PKT_W(PKT_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .fillThr(fillThr), .drainThr(drainThr),
    .maxBurst(maxBurst), .latCfg(latCfg), .hostPend(hostPend), .busGnt(busGnt),
    .hostValid(hostValid), .hostLast(hostLast), .macPop(macPop),
    .usedDw(usedDw), .pktCnt(pktCnt), .full(full), .empty(empty),
    .headLast(macLast), .busReq(busReq), .busOwn(busOwn),
    .macValid(macValid), .strobe(strobe)
  );

  txdma_datapath #(
    .DEPTH_DW(DEPTH_DW), .DATA_W(DATA_W), .MAX_PKT(MAX_PKT),
    .CNT_W(CNT_W), .PKT_W(PKT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(hostData),
    .wrLast(hostLast), .rdData(macData), .rdLast(macLast),
    .usedDw(usedDw), .pktCnt(pktCnt), .full(full), .empty(empty)
  );
endmodule

// File: tb/tb_tx_fifo_dma_ctrl.sv
module tb_tx_fifo_dma_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  fillThr, drainThr;
  logic [7:0]  maxBurst, latCfg;
  logic        hostPend, busGnt, hostValid, hostLast, macPop;
  logic [31:0] hostData;
  logic        busReq, busOwn, macValid, macLast;
  logic [31:0] macData;

  int total = 0;
  int bad = 0;
  int dataCtr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tx_fifo_dma_ctrl dut (
    .clk(clk), .rstN(rstN), .fillThr(fillThr), .drainThr(drainThr),
    .maxBurst(maxBurst), .latCfg(latCfg), .hostPend(hostPend), .busGnt(busGnt),
    .busReq(busReq), .busOwn(busOwn), .hostValid(hostValid), .hostData(hostData),
    .hostLast(hostLast), .macPop(macPop), .macValid(macValid),
    .macData(macData), .macLast(macLast)
  );

  // {maxBurst setting, expected dwords in the burst}
  localparam int VEC[5][2] = '{'{4, 4}, '{1, 1}, '{0, 128}, '{200, 128}, '{128, 128}};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; fillThr = 6'd1; drainThr = 6'd1; maxBurst = 8'd0;
    latCfg = 8'd255; hostPend = 1'b0; busGnt = 1'b0; hostValid = 1'b0;
    hostLast = 1'b0; hostData = '0; macPop = 1'b0; dataCtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // One tenure; returns the number of dwords written
  task automatic fill(input int mb, input int lastAt, input bit every, output int cnt);
    maxBurst = mb[7:0]; busGnt = 1'b1; hostValid = 1'b1; hostPend = 1'b1; cnt = 0;
    forever begin
      @(negedge clk);
      if (busOwn) begin
        hostData = dataCtr;
        hostLast = every || (lastAt != 0 && cnt + 1 == lastAt);
        dataCtr++;
        cnt++;
      end else if (cnt > 0) break;
    end
    busGnt = 1'b0; hostValid = 1'b0; hostLast = 1'b0;
  endtask

  task automatic popCheck(input string req, input int n, input int start, input int lastIdx);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      if (!macValid || macData != 32'(start + i) || macLast != (i == lastIdx)) errs++;
      macPop = 1'b1;
      @(negedge clk);
    end
    macPop = 1'b0;
    check(req, errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    // R11 reset state
    doReset();
    check("R11 busReq", busReq, 0);
    check("R11 busOwn", busOwn, 0);
    check("R11 macValid", macValid, 0);

    // R4 burst length table
    for (int i = 0; i < 5; i++) begin
      doReset();
      fill(VEC[i][0], 0, 0, cnt);
      check("R4 burst length", cnt, VEC[i][1]);
    end

    // R1 fill threshold
    doReset();
    fillThr = 6'd63; hostPend = 1'b1;
    @(negedge clk);
    check("R1 request when free >= thr", busReq, 1);
    fill(10, 0, 0, cnt);
    check("R1 no request below thr", busReq, 0);
    fillThr = 6'd62;
    @(negedge clk);
    check("R1 request after lower thr", busReq, 1);
    hostPend = 1'b0;
    @(negedge clk);
    check("R1 no request without pending", busReq, 0);

    // R2 packet limit
    doReset();
    fill(0, 0, 1, cnt);
    check("R2 burst ends at fourth packet", cnt, 4);
    check("R2 request held off", busReq, 0);
    popCheck("R2 pop one packet", 1, 0, 0);
    check("R2 request resumes", busReq, 1);

    // R5 full FIFO
    doReset();
    fillThr = 6'd0;
    for (int k = 0; k < 3; k++) fill(0, 0, 0, cnt);
    fill(116, 0, 0, cnt);
    fill(0, 0, 0, cnt);
    check("R5 burst ends at full", cnt, 12);
    check("R5 no request when full", busReq, 0);

    // R3 / R6 latency timer with grant withdrawn
    doReset();
    latCfg = 8'd3; hostPend = 1'b1; busGnt = 1'b1;
    @(negedge clk);
    check("R3 own after grant", busOwn, 1);
    busGnt = 1'b0; n = 1;
    forever begin
      @(negedge clk);
      if (!busOwn) break;
      n++;
    end
    check("R6 owned cycles", n, 4);

    // R6 / R7 expired timer
    doReset();
    latCfg = 8'd0; hostPend = 1'b1; busGnt = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 kept with grant", busOwn, 1);
    busGnt = 1'b0;
    @(negedge clk);
    check("R7 ends at next edge", busOwn, 0);

    // R8 / R10 drain threshold and order
    doReset();
    drainThr = 6'd2;
    fill(10, 0, 0, cnt);
    check("R8 hold below drain thr", macValid, 0);
    fill(10, 0, 0, cnt);
    check("R8 offer at drain thr", macValid, 1);
    popCheck("R10 order first", 5, 0, -1);
    check("R8 stays valid mid packet", macValid, 1);
    popCheck("R10 order rest", 15, 5, -1);
    check("R8 empty not valid", macValid, 0);

    doReset();
    drainThr = 6'd2;
    fill(3, 3, 0, cnt);
    check("R8 complete packet offered", macValid, 1);
    popCheck("R10 packet with last", 3, 0, 2);

    // R9 drain threshold zero
    doReset();
    drainThr = 6'd0;
    fill(7, 0, 0, cnt);
    check("R9 seven dwords held", macValid, 0);
    fill(1, 0, 0, cnt);
    check("R9 eight dwords offered", macValid, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule